// File: doc/BRIEF.md
# Partitioned Subword Saturating ALU

This execution unit takes two 64-bit register operands, treats each as four independent 16-bit lanes, and applies one packed operation to all lanes at once: addition, subtraction, a left shift, a logical right shift or an arithmetic right shift. The adder is cut at each lane edge, so a carry or borrow out of one lane never reaches its neighbour.

Addition and subtraction each take an overflow policy with the request. The result can wrap modulo 2^16, clamp to the signed 16-bit range, or clamp to the unsigned 16-bit range. Shifts use a single 4-bit amount for every lane and do not look at the overflow policy. Result and valid flag are registered. A request seen at one clock edge is visible after that edge, and a new request can be issued every cycle.

Top module: `packed_sat_alu`

## Requirements
- R1: Lane k occupies bits [16k+15:16k] of every operand and of the result. Opcode 0 with mode 0 adds lane by lane modulo 2^16, and no carry passes between lanes.
- R2: Opcode 1 with mode 0 subtracts operand B from operand A lane by lane modulo 2^16, and no borrow passes between lanes.
- R3: Mode 1 (signed) on opcode 0 or 1 treats lanes as two's complement. A lane result above 32767 becomes 0x7FFF, and one below -32768 becomes 0x8000.
- R4: Mode 2 (unsigned) on opcode 0 turns a lane sum above 0xFFFF into 0xFFFF.
- R5: Mode 2 (unsigned) on opcode 1 turns a lane difference below zero into 0x0000.
- R6: Opcode 2 shifts every lane left by shamt_i (0 to 15), filling with zeros.
- R7: Opcode 3 shifts every lane right by shamt_i, filling with zeros.
- R8: Opcode 4 shifts every lane right by shamt_i, filling with that lane's own bit 15.
- R9: For opcodes 2, 3 and 4 the mode input has no effect on the result. Mode 3 on add and subtract behaves as mode 0.
- R10: With req_valid_i high at an edge, res_o takes the result and res_valid_o is high after that edge. With req_valid_i low, res_valid_o is low and res_o holds. A request is accepted every cycle.
- R11: While rst_ni is low, res_o is zero and res_valid_o is low.
- R12: Opcodes 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 shl, 3 shr, 4 sra |
| sat_mode_i | input | 2 | Overflow policy: 0 wrap, 1 signed, 2 unsigned |
| shamt_i | input | 4 | Shift amount for all lanes |
| opa_i | input | 64 | Operand A, four packed lanes |
| opb_i | input | 64 | Operand B, four packed lanes |
| res_o | output | 64 | Registered packed result |
| res_valid_o | output | 1 | Result produced by the previous cycle's request |

## Verification
Every result is due exactly one clock edge after its request, because a single register stage holds both res_o and res_valid_o. The bench drives each request on a falling edge and checks the outputs on the next falling edge, which is half a cycle after the capturing rising edge. For back-to-back traffic it checks request k while it presents request k+1 on the same falling edge. For idle cycles it waits several edges and confirms that the result holds and the valid flag stays low.

// File: rtl/psalu_pkg.sv
package psalu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SHL = 3'd2,
    OP_SHR = 3'd3,
    OP_SRA = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2
  } sat_mode_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
  import psalu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W-1:0] b_eff, raw;
  logic [W:0]   sum;
  logic         s_ovf, u_ovf;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    raw   = sum[W-1:0];
    s_ovf = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
    // carry out is set when no borrow occurs in subtraction
    u_ovf = sub_i ? ~sum[W] : sum[W];
    unique case (mode_i)
      SAT_SIGNED:   y_o = s_ovf ? (a_i[W-1] ? SMIN : SMAX) : raw;
      SAT_UNSIGNED: y_o = u_ovf ? (sub_i ? '0 : UMAX) : raw;
      default:      y_o = raw;
    endcase
  end

  always_comb begin
    if (mode_i == SAT_SIGNED && a_i[W-1] == b_eff[W-1])
      assert_signed_sign_R3: assert (y_o[W-1] == a_i[W-1]);
    if (mode_i == SAT_UNSIGNED && !sub_i)
      assert_uadd_floor_R4: assert (y_o >= a_i && y_o >= b_i);
    if (mode_i == SAT_UNSIGNED && sub_i)
      assert_usub_ceiling_R5: assert (y_o <= a_i);
  end
endmodule

// File: rtl/lane_shift.sv
module lane_shift
  import psalu_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [SHW-1:0] sh_i,
  input  logic [1:0]     kind_i,
  output logic [W-1:0]   y_o
);
  always_comb begin
    unique case (kind_i)
      SH_LEFT: y_o = a_i << sh_i;
      SH_RLOG: y_o = a_i >> sh_i;
      default: y_o = W'($signed(a_i) >>> sh_i);
    endcase
  end

  always_comb begin
    if (kind_i == SH_RARI)
      assert_sra_sign_R8: assert (y_o[W-1] == a_i[W-1]);
    if (kind_i == SH_RLOG && sh_i != '0)
      assert_shr_zero_fill_R7: assert (y_o[W-1] == 1'b0);
    if (kind_i == SH_LEFT && sh_i != '0)
      assert_shl_zero_fill_R6: assert (y_o[0] == 1'b0);
  end
endmodule

// File: rtl/packed_sat_alu.sv
module packed_sat_alu
  import psalu_pkg::*;
#(
  parameter  int unsigned LANE_W = 16,
  parameter  int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned SHW    = $clog2(LANE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        sat_mode_i,
  input  logic [SHW-1:0]    shamt_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o
);
  logic [DATA_W-1:0] arith_y, shift_y, next_y;
  logic              is_sub;
  logic [1:0]        sh_kind;

  always_comb begin
    is_sub = (op_i == OP_SUB);
    unique case (op_i)
      OP_SHR:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_addsub #(.W(LANE_W)) u_as (
      .a_i   (opa_i[g*LANE_W +: LANE_W]),
      .b_i   (opb_i[g*LANE_W +: LANE_W]),
      .sub_i (is_sub),
      .mode_i(sat_mode_i),
      .y_o   (arith_y[g*LANE_W +: LANE_W])
    );
    lane_shift #(.W(LANE_W), .SHW(SHW)) u_sh (
      .a_i   (opa_i[g*LANE_W +: LANE_W]),
      .sh_i  (shamt_i),
      .kind_i(sh_kind),
      .y_o   (shift_y[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB:         next_y = arith_y;
      OP_SHL, OP_SHR, OP_SRA: next_y = shift_y;
      default:                next_y = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) res_o <= next_y;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  assert_idle_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(res_o));
  assert_reserved_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i > 3'd4) |=> (res_o == '0));

  always_comb begin
    if (!rst_ni) assert_reset_clear_R11: assert (res_o == '0 && !res_valid_o);
  end
endmodule

// File: tb/packed_sat_alu_test.sv
`timescale 1ns/1ps
module packed_sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [2:0]  op;
  logic [1:0]  md;
  logic [3:0]  sh;
  logic [63:0] a, b;
  logic [63:0] res;
  logic        vld;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  always #10 clk = ~clk;

  packed_sat_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .op_i(op),
    .sat_mode_i(md), .shamt_i(sh), .opa_i(a), .opb_i(b),
    .res_o(res), .res_valid_o(vld)
  );

  function automatic logic [15:0] ref_lane(int o, int m, int s, int x, int y);
    int r;
    int sx = (x >= 32768) ? x - 65536 : x;
    int sy = (y >= 32768) ? y - 65536 : y;
    case (o)
      0: begin
        if (m == 1) begin
          r = sx + sy; if (r > 32767) r = 32767; if (r < -32768) r = -32768;
        end else if (m == 2) begin
          r = x + y; if (r > 65535) r = 65535;
        end else r = x + y;
      end
      1: begin
        if (m == 1) begin
          r = sx - sy; if (r > 32767) r = 32767; if (r < -32768) r = -32768;
        end else if (m == 2) begin
          r = x - y; if (r < 0) r = 0;
        end else r = x - y;
      end
      2: r = x << s;
      3: r = x >> s;
      4: r = sx >>> s;
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref64(int o, int m, int s, logic [63:0] x, logic [63:0] y);
    logic [63:0] r;
    for (int k = 0; k < 4; k++)
      r[k*16 +: 16] = ref_lane(o, m, s, int'(x[k*16 +: 16]), int'(y[k*16 +: 16]));
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(int o, int m, int s, logic [63:0] x, logic [63:0] y);
    req = 1'b1; op = 3'(o); md = 2'(m); sh = 4'(s); a = x; b = y;
  endtask

  task automatic run_op(string tag, int o, int m, int s, logic [63:0] x, logic [63:0] y);
    @(negedge clk);
    drive(o, m, s, x, y);
    @(negedge clk);
    req = 1'b0;
    check(tag, res, ref64(o, m, s, x, y));
    check({tag, " valid"}, {63'd0, vld}, 64'd1);
  endtask

  task automatic t_reset();
    check("R11 reset result", res, 64'd0);
    check("R11 reset valid", {63'd0, vld}, 64'd0);
  endtask

  task automatic t_add_wrap();
    run_op("R1 add wrap carry cut", 0, 0, 0, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFF_0001);
    check("R1 add lane isolation", res, 64'h0000_0000_0000_1235);
    run_op("R1 add wrap mode3", 0, 3, 0, 64'h7FFF_FFFF_0010_0000, 64'h0001_0002_0020_0000);
  endtask

  task automatic t_sub_wrap();
    run_op("R2 sub wrap borrow cut", 1, 0, 0, 64'h0000_0005_8000_0000, 64'h0001_0003_0001_0001);
    check("R2 sub lane isolation", res, 64'hFFFF_0002_7FFF_FFFF);
  endtask

  task automatic t_signed_sat();
    run_op("R3 signed add", 1'b0, 1, 0, 64'h7FFF_8000_7000_1000, 64'h0001_FFFF_1000_F000);
    check("R3 signed add clamp", res, 64'h7FFF_8000_7FFF_0000);
    run_op("R3 signed sub", 1, 1, 0, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_FFFF);
    check("R3 signed sub clamp", res, 64'h8000_7FFF_FFFE_0000);
  endtask

  task automatic t_unsigned();
    run_op("R4 unsigned add", 0, 2, 0, 64'hFFFF_8000_0001_FFF0, 64'h0001_8000_0002_0001);
    check("R4 unsigned add clamp", res, 64'hFFFF_FFFF_0003_FFF1);
    run_op("R5 unsigned sub", 1, 2, 0, 64'h0000_0005_0005_FFFF, 64'h0001_0006_0005_0001);
    check("R5 unsigned sub clamp", res, 64'h0000_0000_0000_FFFE);
  endtask

  task automatic t_shifts();
    logic [63:0] x = 64'h8001_7FFF_F0F0_0001;
    run_op("R6 shl 4", 2, 0, 4, x, 64'd0);
    run_op("R6 shl 15", 2, 0, 15, x, 64'd0);
    run_op("R7 shr 0", 3, 0, 0, x, 64'd0);
    run_op("R7 shr 15", 3, 0, 15, x, 64'd0);
    check("R7 shr 15 value", res, 64'h0001_0000_0001_0000);
    run_op("R8 sra 3", 4, 0, 3, x, 64'd0);
    run_op("R8 sra 15", 4, 0, 15, x, 64'd0);
    check("R8 sra 15 value", res, 64'hFFFF_0000_FFFF_0000);
  endtask

  task automatic t_mode_ignored();
    logic [63:0] x = 64'hC001_4000_FFFF_0123;
    for (int m = 0; m < 4; m++) begin
      run_op($sformatf("R9 shl mode %0d", m), 2, m, 2, x, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R9 shl mode ignored", res, 64'h0004_0000_FFFC_048C);
      run_op($sformatf("R9 sra mode %0d", m), 4, m, 1, x, 64'd0);
    end
  endtask

  task automatic t_reserved();
    for (int o = 5; o < 8; o++)
      run_op($sformatf("R12 reserved op %0d", o), o, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_back_to_back();
    logic [63:0] xs [6];
    logic [63:0] ys [6];
    int          os [6];
    for (int i = 0; i < 6; i++) begin
      xs[i] = {16'(i * 4099), 16'(i * 40000), 16'(65535 - i), 16'(i * 3)};
      ys[i] = {16'(i * 777), 16'(i * 30001), 16'(i + 1), 16'(32767 + i)};
      os[i] = i % 5;
    end
    @(negedge clk);
    drive(os[0], 1, 1, xs[0], ys[0]);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check($sformatf("R10 back-to-back %0d", i - 1), res, ref64(os[i-1], 1, 1, xs[i-1], ys[i-1]));
      check("R10 back-to-back valid", {63'd0, vld}, 64'd1);
      if (i < 6) drive(os[i], 1, 1, xs[i], ys[i]);
      else req = 1'b0;
    end
  endtask

  task automatic t_hold();
    logic [63:0] kept;
    run_op("R10 hold setup", 0, 0, 0, 64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101);
    kept = res;
    a = 64'hDEAD_BEEF_DEAD_BEEF;
    op = 3'd2;
    repeat (3) @(negedge clk);
    check("R10 idle holds result", res, kept);
    check("R10 idle valid low", {63'd0, vld}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; op = '0; md = '0; sh = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_wrap();
    t_sub_wrap();
    t_signed_sat();
    t_unsigned();
    t_shifts();
    t_mode_ignored();
    t_reserved();
    t_back_to_back();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule